// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block produces the horizontal timing of a raster line for a display output that runs either as a computer monitor (CRT) or as a television signal in NTSC or PAL form. It runs on the pixel clock. A line counter divides every line into an active stretch, where the display-enable output is high, and a blanking stretch. A sync pulse is placed inside the blanking stretch. A one-cycle marker flags the last pixel of every line.

The active width, the blanking length, the sync placement and the sync polarity come from programmed fields, most of them in units of 8 pixels. The blanking length depends on the output mode. The fields are captured only when a line wraps, so changing them partway through a line never alters that line. An error output reports field combinations that break the programming rules.

Top module: `hline_timing`

## Requirements
- R1: Every line begins with its active stretch. `de_o` is high for exactly (`width_i`+1)×8 pixels, starting at the first pixel after reset or after each line-end pixel, and is low for the rest of the line.
- R2: With `mode_i` = 2'b00 (CRT) the blanking stretch lasts (`blank_i`+1)×8 pixels.
- R3: With `mode_i` = 2'b01 (NTSC TV) the blanking stretch lasts `blank_i`×8+6 pixels.
- R4: With `mode_i` = 2'b10 or 2'b11 (PAL TV) the blanking stretch lasts `blank_i`×8+7 pixels.
- R5: `line_end_o` is high for one cycle, on the last pixel of every line, and low on every other pixel.
- R6: The sync pulse starts `sync_off_i`×8 pixels after the first blanking pixel and lasts (`sync_wid_i`+1)×8 pixels, cut off at the line end. `hsync_o` equals the pulse when `sync_pol_i` is 1 and equals its inverse when `sync_pol_i` is 0.
- R7: In CRT mode, `cfg_err_o` is high for the whole line when the line's `blank_i` is below 3. The TV modes have no such minimum.
- R8: `cfg_err_o` is high for the whole line when (`sync_off_i`+1)+(`sync_wid_i`+1) exceeds `blank_i`+1.
- R9: All field and mode inputs are captured while reset is active and on the clock edge that ends a line. Changes at any other time have no effect until the next line.
- R10: While `rst_n` is low at a clock edge, the counter clears. From that edge on, `de_o`, `line_end_o` and `cfg_err_o` are 0 and `hsync_o` sits at its inactive level. The first active pixel follows the first edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Output mode: 00 CRT, 01 NTSC, 10/11 PAL |
| width_i | input | 7 | Active width in 8-pixel units, minus one |
| blank_i | input | 6 | Blanking length field |
| sync_off_i | input | 5 | Sync start, in 8-pixel units after blanking begins |
| sync_wid_i | input | 4 | Sync length in 8-pixel units, minus one |
| sync_pol_i | input | 1 | 1: sync active high, 0: sync active low |
| de_o | output | 1 | Display enable |
| line_end_o | output | 1 | Last-pixel marker |
| hsync_o | output | 1 | Horizontal sync |
| cfg_err_o | output | 1 | Programming-rule violation for the current line |

## Verification
Two functions meet in the same cycle at the line boundary: the last-pixel marker of the old line and the capture of new fields for the next line. The bench changes every field for the next line partway through the current line, well before that line's last pixel. It then compares each pixel of both lines against a model built from the fields that should apply. A line cut short, a sync pulse in the wrong place or a wrong enable at the first pixel of the new line shows up as a mismatch. One line is set up so that its sync pulse runs exactly into the last pixel, which makes the sync end and the line end fall on the same edge.

// File: rtl/hlt_pkg.sv
// Package: shared widths, output-mode codes and the line configuration
// record. Assumes 8-pixel programming units; TV blanking adds a fixed tail.
package hlt_pkg;
    localparam int WID_W       = 7;
    localparam int BLK_W       = 6;
    localparam int SOFF_W      = 5;
    localparam int SWID_W      = 4;
    localparam int UNIT        = 8;
    localparam int NTSC_EXTRA  = 6;
    localparam int PAL_EXTRA   = 7;
    localparam int CRT_MIN_BLK = 3;
    localparam int MAX_LINE    = ((1 << WID_W) + (1 << BLK_W)) * UNIT;
    localparam int CNT_W       = $clog2(MAX_LINE + 1);

    typedef enum logic [1:0] {
        OUT_CRT  = 2'b00,
        OUT_NTSC = 2'b01,
        OUT_PAL  = 2'b10,
        OUT_PAL2 = 2'b11
    } out_mode_e;

    typedef struct packed {
        out_mode_e           mode;
        logic [WID_W-1:0]    width;
        logic [BLK_W-1:0]    blank;
        logic [SOFF_W-1:0]   soff;
        logic [SWID_W-1:0]   swid;
        logic                pol;
    } hcfg_t;

    // Active pixels of a line for a given configuration.
    function automatic logic [CNT_W-1:0] active_len(hcfg_t c);
        return CNT_W'((32'(c.width) + 1) * UNIT);
    endfunction

    // Blanking pixels of a line; the formula depends on the output mode.
    function automatic logic [CNT_W-1:0] blank_len(hcfg_t c);
        case (c.mode)
            OUT_CRT:  return CNT_W'((32'(c.blank) + 1) * UNIT);
            OUT_NTSC: return CNT_W'(32'(c.blank) * UNIT + NTSC_EXTRA);
            default:  return CNT_W'(32'(c.blank) * UNIT + PAL_EXTRA);
        endcase
    endfunction
endpackage

// File: rtl/hlt_cfg_latch.sv
// Configuration shadow register. Captures the live inputs while reset is
// active and when the load strobe (line end) is high; holds otherwise.
module hlt_cfg_latch
    import hlt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  hcfg_t cfg_i,
    output hcfg_t cfg_o
);
    hcfg_t shadow_q;

    // Capture the next line's configuration only at a line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            shadow_q <= cfg_i;
        end
    end

    assign cfg_o = shadow_q;
endmodule

// File: rtl/hlt_counter.sv
// Pixel counter. Counts 0..last_i and wraps. The run flag is held off during
// reset so that the first pixel after reset is pixel 0. Assumes last_i >= 1.
module hlt_counter
    import hlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] last_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             end_o
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign end_o = run_q && (cnt_q == last_i);

    // Advance the pixel position, restarting after the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (!run_q || end_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign run_o = run_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/hlt_decode.sv
// Output decode. Turns the pixel position and the captured configuration
// into display enable, sync and the rule-violation flag. All outputs are
// inactive while run_i is low.
module hlt_decode
    import hlt_pkg::*;
(
    input  hcfg_t            cfg_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             de_o,
    output logic             hsync_o,
    output logic             err_o
);
    logic [CNT_W-1:0] act_len;
    logic [CNT_W:0]   sync_beg;
    logic [CNT_W:0]   sync_fin;
    logic             in_sync;
    logic             crt_short;
    logic             sync_overrun;

    // Region boundaries of the current line.
    always_comb begin
        act_len  = active_len(cfg_i);
        sync_beg = (CNT_W+1)'(32'(act_len) + 32'(cfg_i.soff) * UNIT);
        sync_fin = (CNT_W+1)'(32'(sync_beg) + (32'(cfg_i.swid) + 1) * UNIT);
    end

    // Region decode and polarity.
    always_comb begin
        de_o    = run_i && (cnt_i < act_len);
        in_sync = run_i && ((CNT_W+1)'(cnt_i) >= sync_beg)
                        && ((CNT_W+1)'(cnt_i) <  sync_fin);
        hsync_o = cfg_i.pol ? in_sync : !in_sync;
    end

    // Programming-rule checks on the captured fields.
    always_comb begin
        crt_short    = (cfg_i.mode == OUT_CRT) && (32'(cfg_i.blank) < CRT_MIN_BLK);
        sync_overrun = (32'(cfg_i.soff) + 32'(cfg_i.swid) + 2) > (32'(cfg_i.blank) + 1);
        err_o        = run_i && (crt_short || sync_overrun);
    end
endmodule

// File: rtl/hline_timing.sv
// Top level: horizontal line timing generator. Captures the fields at the
// line boundary, counts pixels and decodes enable, sync, line end and error.
module hline_timing
    import hlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [WID_W-1:0]  width_i,
    input  logic [BLK_W-1:0]  blank_i,
    input  logic [SOFF_W-1:0] sync_off_i,
    input  logic [SWID_W-1:0] sync_wid_i,
    input  logic              sync_pol_i,
    output logic              de_o,
    output logic              line_end_o,
    output logic              hsync_o,
    output logic              cfg_err_o
);
    hcfg_t            live_cfg;
    hcfg_t            shadow;
    logic             run_q;
    logic [CNT_W-1:0] pix_cnt;
    logic [CNT_W-1:0] last_pix;

    // Pack the live inputs into one configuration record.
    always_comb begin
        live_cfg.mode  = out_mode_e'(mode_i);
        live_cfg.width = width_i;
        live_cfg.blank = blank_i;
        live_cfg.soff  = sync_off_i;
        live_cfg.swid  = sync_wid_i;
        live_cfg.pol   = sync_pol_i;
    end

    // Index of the last pixel of the current line.
    always_comb begin
        last_pix = active_len(shadow) + blank_len(shadow) - 1'b1;
    end

    hlt_cfg_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (line_end_o),
        .cfg_i  (live_cfg),
        .cfg_o  (shadow)
    );

    hlt_counter u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_i (last_pix),
        .run_o  (run_q),
        .cnt_o  (pix_cnt),
        .end_o  (line_end_o)
    );

    hlt_decode u_dec (
        .cfg_i   (shadow),
        .run_i   (run_q),
        .cnt_i   (pix_cnt),
        .de_o    (de_o),
        .hsync_o (hsync_o),
        .err_o   (cfg_err_o)
    );
endmodule

// File: rtl/hline_timing_chk.sv
// Assertion checker for hline_timing, attached by bind. Assumes the
// captured configuration and the run flag are visible under their top names.
module hline_timing_chk
    import hlt_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  de_o,
    input logic  line_end_o,
    input logic  hsync_o,
    input logic  cfg_err_o,
    input logic  run_i,
    input hcfg_t cfg_i
);
    logic armed_q;

    // Marks cycles at least one edge after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R5: the line-end marker never lasts two cycles.
    p_end_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |=> !line_end_o);

    // R1: a new line opens with display enable.
    p_de_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |=> de_o);

    // R6: sync stays inactive throughout the active stretch.
    p_sync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_o == !cfg_i.pol));

    // R9: the captured configuration only moves after a line end.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(line_end_o)) |-> $stable(cfg_i));

    // R7: a short CRT blanking always raises the error output.
    p_crt_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cfg_i.mode == OUT_CRT && cfg_i.blank < BLK_W'(CRT_MIN_BLK)) |-> cfg_err_o);

    // R10: a reset edge leaves enable, marker and error low.
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!de_o && !line_end_o && !cfg_err_o));
endmodule

bind hline_timing hline_timing_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .de_o       (de_o),
    .line_end_o (line_end_o),
    .hsync_o    (hsync_o),
    .cfg_err_o  (cfg_err_o),
    .run_i      (run_q),
    .cfg_i      (shadow)
);

// File: tb/hline_timing_tb.sv
module hline_timing_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = '0;
    logic [6:0] width_i = '0;
    logic [5:0] blank_i = '0;
    logic [4:0] sync_off_i = '0;
    logic [3:0] sync_wid_i = '0;
    logic       sync_pol_i = 1'b0;
    logic       de_o, line_end_o, hsync_o, cfg_err_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic  de;
        logic  hs;
        logic  le;
        logic  err;
        string ltag;
        string etag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    hline_timing u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .width_i(width_i),
        .blank_i(blank_i), .sync_off_i(sync_off_i), .sync_wid_i(sync_wid_i),
        .sync_pol_i(sync_pol_i), .de_o(de_o), .line_end_o(line_end_o),
        .hsync_o(hsync_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic apply(int m, int w, int nd, int off, int wid, int pol);
        mode_i     = 2'(m);
        width_i    = 7'(w);
        blank_i    = 6'(nd);
        sync_off_i = 5'(off);
        sync_wid_i = 4'(wid);
        sync_pol_i = 1'(pol);
    endtask

    // Driver: expected pixels of one line, from the requirement formulas.
    task automatic push_line(int m, int w, int nd, int off, int wid, int pol, output int len);
        int    act, blk, s0, s1;
        bit    err;
        string lt, et;
        act = (w + 1) * 8;
        if (m == 0)      begin blk = (nd + 1) * 8; lt = "R2"; end
        else if (m == 1) begin blk = nd * 8 + 6;   lt = "R3"; end
        else             begin blk = nd * 8 + 7;   lt = "R4"; end
        s0  = act + off * 8;
        s1  = s0 + (wid + 1) * 8;
        err = (m == 0 && nd < 3) || (off + wid + 2 > nd + 1);
        et  = (m == 0 && nd < 3) ? "R7" : "R8";
        len = act + blk;
        for (int p = 0; p < len; p++) begin
            exp_t e;
            bit   ins;
            ins   = (p >= s0) && (p < s1);
            e.de  = (p < act);
            e.hs  = pol ? ins : !ins;
            e.le  = (p == len - 1);
            e.err = err;
            e.ltag = lt;
            e.etag = et;
            q.push_back(e);
        end
    endtask

    // Next line: apply fields mid-line, queue them, wait past the boundary.
    task automatic next_line(int m, int w, int nd, int off, int wid, int pol);
        int len;
        apply(m, w, nd, off, wid, pol);
        push_line(m, w, nd, off, wid, pol, len);
        while (q.size() > len) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected pixel per cycle and compares.
    initial begin
        wait (mon_en);
        forever begin
            @(negedge clk);
            if (mon_en && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check("R1/R9", "de_o", de_o, e.de);
                check({e.ltag, "/R5"}, "line_end_o", line_end_o, e.le);
                check("R6", "hsync_o", hsync_o, e.hs);
                check(e.etag, "cfg_err_o", cfg_err_o, e.err);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int len;
        // R10: reset state, first line fields captured during reset (R9).
        apply(0, 0, 3, 0, 2, 1);
        repeat (4) @(negedge clk);
        check("R10", "de_o reset", de_o, 1'b0);
        check("R10", "line_end_o reset", line_end_o, 1'b0);
        check("R10", "hsync_o reset", hsync_o, 1'b0);
        check("R10", "cfg_err_o reset", cfg_err_o, 1'b0);
        push_line(0, 0, 3, 0, 2, 1, len);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        next_line(1, 1, 2, 0, 0, 0);    // R3 NTSC
        next_line(2, 0, 2, 1, 0, 1);    // R4 PAL code 10
        next_line(3, 2, 1, 0, 0, 1);    // R4 PAL code 11
        next_line(0, 0, 2, 0, 0, 1);    // R7 CRT below minimum
        next_line(1, 0, 1, 0, 0, 0);    // R7 no minimum in TV mode
        next_line(0, 1, 4, 2, 2, 0);    // R8 sync overrun, sync meets line end
        next_line(0, 127, 63, 31, 15, 1); // R2 widest line
        next_line(0, 0, 3, 0, 2, 0);    // R6 low polarity
        while (q.size() > 0) @(negedge clk);
        mon_en = 1'b0;
        // R10: reset in the middle of a line.
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "de_o mid reset", de_o, 1'b0);
        check("R10", "line_end_o mid reset", line_end_o, 1'b0);
        check("R10", "hsync_o mid reset", hsync_o, 1'b1);
        check("R10", "cfg_err_o mid reset", cfg_err_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "de_o first pixel", de_o, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule